// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block derives the serial clock of an I2C master from a fast input clock. A coarse power-of-two predivider and an 8-bit fine rate value together set the bit period, and a filter bit lengthens the period by a fixed amount. The block drives a serial-clock phase output with a 50% duty cycle and a one-cycle quarter strobe. The bit engine uses that strobe to place data changes and samples inside each bit.

Software computes the mode and rate values for a target bus frequency and presents them on the configuration inputs. The block takes a copy of them when it is enabled and again at every period boundary. Because of this, a change made in the middle of a period never shortens or stretches the clock phase that is already running. While the block is disabled, all counting stops and the clock output rests high, which is the released state of the bus.

Top module: `i2c_rate_gen`

## Requirements
- R1: The mode input holds three fields. Bit 0 is the enable, bits 2:1 are the predivider select, and bit 3 is the filter enable.
- R2: While the enable bit is 0, from the next clock edge on, `scl_o` is 1 and `qtr_o` is 0. When enable is set again, the period restarts from its beginning.
- R3: Predivider select values 0, 1, 2 and 3 give predivider factors of 32, 16, 8 and 4, that is 2^(5-select).
- R4: One full serial clock period lasts predivider × 2 × (rate + 3 + 2 × filter) input clock cycles, so the serial frequency is the input frequency divided by that product. Each quarter period lasts one quarter of that count.
- R5: Setting the filter bit adds 4 × predivider input cycles to the period, with the rate value unchanged.
- R6: `qtr_o` is high for exactly one cycle at the end of each quarter period. Let edge k be the first clock edge that samples the enable as 1. The first strobe is visible after edge k+Q, where Q is the quarter length, and further strobes follow every Q cycles.
- R7: `scl_o` is high for the first half of each period and low for the second half. It falls together with the second strobe of the period and rises together with the fourth strobe.
- R8: A change to the rate, predivider select or filter bit made while the block is enabled has no effect until the next period boundary, which is the edge that raises `scl_o`. The new values apply from that edge on.
- R9: The full rate range from 0 to 255 is honoured, including both end values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 4 | Enable (bit 0), predivider select (bits 2:1), filter enable (bit 3) |
| rate_i | input | RATE_W | Fine rate value |
| scl_o | output | 1 | Serial clock phase, 1 when released |
| qtr_o | output | 1 | One-cycle strobe at each quarter-period end |

## Verification
The hardest case to reach from the ports is a configuration write that lands in the middle of a running period. The old values must then finish the current period exactly, and the new values must take over at the boundary edge and at no other edge. The stimulus enables a short configuration and rewrites all three fields partway through the first quarter's successor. It then checks every cycle against a strobe and clock schedule built from two different quarter lengths joined at the computed boundary. A second directed case drops the enable while the clock is low and changes the rate during the idle time. It checks that the output returns high at once and that the next enable restarts a clean period.

// File: rtl/i2c_rate_gen.sv
module i2c_rate_gen #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              scl_o,
  output logic              qtr_o
);

  localparam int FINE_W = RATE_W + 1;

  logic              en_q;
  logic [1:0]        sel_q;
  logic              filt_q;
  logic [RATE_W-1:0] rate_q;
  logic [3:0]        pre_cnt;
  logic [FINE_W-1:0] fine_cnt;
  logic [1:0]        qidx;

  // half of the predivider: 16, 8, 4, 2 for select 0..3
  wire [3:0]        pre_last  = 4'((5'd16 >> sel_q) - 5'd1);
  wire [FINE_W-1:0] fine_last = FINE_W'(rate_q) + FINE_W'(filt_q ? 4 : 2);
  wire              pre_end   = (pre_cnt == pre_last);
  wire              fine_end  = (fine_cnt == fine_last);
  wire              q_end     = pre_end && fine_end;
  wire              wrap      = q_end && (qidx == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      sel_q    <= '0;
      filt_q   <= 1'b0;
      rate_q   <= '0;
      pre_cnt  <= '0;
      fine_cnt <= '0;
      qidx     <= '0;
      scl_o    <= 1'b1;
      qtr_o    <= 1'b0;
    end else if (!mode_i[0]) begin
      en_q     <= 1'b0;
      pre_cnt  <= '0;
      fine_cnt <= '0;
      qidx     <= '0;
      scl_o    <= 1'b1;
      qtr_o    <= 1'b0;
    end else if (!en_q) begin
      en_q     <= 1'b1;
      sel_q    <= mode_i[2:1];
      filt_q   <= mode_i[3];
      rate_q   <= rate_i;
      pre_cnt  <= '0;
      fine_cnt <= '0;
      qidx     <= '0;
      scl_o    <= 1'b1;
      qtr_o    <= 1'b0;
    end else begin
      qtr_o   <= q_end;
      pre_cnt <= pre_end ? '0 : pre_cnt + 4'd1;
      if (pre_end)
        fine_cnt <= fine_end ? '0 : fine_cnt + FINE_W'(1);
      if (q_end) begin
        qidx <= qidx + 2'd1;
        if (qidx == 2'd1)
          scl_o <= 1'b0;
      end
      if (wrap) begin
        scl_o  <= 1'b1;
        sel_q  <= mode_i[2:1];
        filt_q <= mode_i[3];
        rate_q <= rate_i;
      end
    end
  end

  assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i[0] |=> (scl_o && !qtr_o));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    qtr_o |=> !qtr_o);

  assert_scl_on_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && (scl_o != $past(scl_o))) |-> qtr_o);

  assert_cfg_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && !($stable(rate_q) && $stable(sel_q) && $stable(filt_q)))
      |-> (qtr_o && scl_o));

  assert_prediv_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> (pre_cnt <= pre_last));

endmodule

// File: tb/i2c_rate_gen_bench.sv
module i2c_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode = 4'd0;
  logic [7:0] rate = 8'd0;
  logic       scl, qtr;
  int         vectors = 0;
  int         errs = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  i2c_rate_gen #(.RATE_W(8)) u_i2c_rate_gen (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .rate_i(rate),
    .scl_o(scl), .qtr_o(qtr));

  function automatic int quarter(int sel, int f, int r);
    return (16 >> sel) * (r + 3 + 2 * f);
  endfunction

  task automatic chk(logic got, logic exp, string tag, int m);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s at m=%0d: got %0b expected %0b", tag, m, got, exp);
    end
  endtask

  // R2: idle outputs
  task automatic idle_check();
    mode = 4'd0;
    @(negedge clk);
    @(negedge clk);
    chk(scl, 1'b1, "R2 idle scl", 0);
    chk(qtr, 1'b0, "R2 idle qtr", 0);
  endtask

  // R1 R3 R4 R5 R6 R7 R9: one full period, every cycle checked
  task automatic run_period(int sel, int f, int r);
    int q;
    idle_check();
    q = quarter(sel, f, r);
    rate = 8'(r);
    mode = {f[0], 2'(sel), 1'b1};
    for (int m = 0; m <= 4 * q + 1; m++) begin
      @(negedge clk);
      chk(qtr, (m > 0) && (m % q == 0), $sformatf("R4 R6 qtr sel=%0d f=%0d rate=%0d", sel, f, r), m);
      chk(scl, (m % (4 * q)) < 2 * q, $sformatf("R7 scl sel=%0d f=%0d rate=%0d", sel, f, r), m);
    end
  endtask

  // R8: rewrite all fields mid-period
  task automatic run_switch();
    int qa, qb, b;
    logic eq, es;
    idle_check();
    qa = quarter(2, 0, 2);
    qb = quarter(3, 1, 9);
    b = 4 * qa;
    rate = 8'd2;
    mode = {1'b0, 2'd2, 1'b1};
    for (int m = 0; m <= b + 4 * qb + 1; m++) begin
      @(negedge clk);
      if (m <= b) begin
        eq = (m > 0) && (m % qa == 0);
        es = (m % (4 * qa)) < 2 * qa;
      end else begin
        eq = ((m - b) % qb == 0);
        es = ((m - b) % (4 * qb)) < 2 * qb;
      end
      chk(qtr, eq, "R8 qtr after rewrite", m);
      chk(scl, es, "R8 scl after rewrite", m);
      if (m == 30) begin
        rate = 8'd9;
        mode = {1'b1, 2'd3, 1'b1};
      end
    end
  endtask

  // R2: disable while scl low, rate change while idle is ignored
  task automatic run_drop();
    int q;
    idle_check();
    q = quarter(3, 0, 0);
    rate = 8'd0;
    mode = {1'b0, 2'd3, 1'b1};
    for (int m = 0; m <= 2 * q + 3; m++) @(negedge clk);
    chk(scl, 1'b0, "R7 scl low before drop", 2 * q + 3);
    mode = 4'd0;
    rate = 8'd255;
    for (int m = 0; m < 6; m++) begin
      @(negedge clk);
      chk(scl, 1'b1, "R2 scl after drop", m);
      chk(qtr, 1'b0, "R2 qtr after drop", m);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(scl, 1'b1, "R2 reset scl", 0);
    chk(qtr, 1'b0, "R2 reset qtr", 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl, 1'b1, "R2 post-reset scl", 0);
    chk(qtr, 1'b0, "R2 post-reset qtr", 0);
    for (int s = 0; s < 4; s++)
      for (int f = 0; f < 2; f++) begin
        run_period(s, f, 0);
        run_period(s, f, 1);
        run_period(s, f, 5);
        run_period(s, f, 255);
      end
    run_period(3, 0, 100);
    run_switch();
    run_drop();
    run_period(1, 1, 7);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule